// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block is a full-duplex asynchronous serial port seen by a processor as four byte registers. A chip select, one register-select line and separate read and write strobes pick the register. With the select line low, a write places a byte in the transmit holding register and a read returns the last received character. With the select line high, a write sets the line format and a read returns the status flags.

The transmitter moves a byte from the holding register into a shift register. It then sends a low start bit, the character bits least significant first, an optional parity bit and one or two high stop bits. The receiver synchronises the incoming line and runs at sixteen ticks per bit. It checks the start bit halfway through, samples each later bit at its centre and places the finished character in the receive register. It records parity, framing and overrun errors. Reading the status register clears the error flags.

Top module: `sercom_port`

## Requirements
- R1: While `cs` is low, strobes have no effect: no register changes, no byte is queued for sending, and `rdata` is 0.
- R2: With `cs` high and `rsel` 0, a write loads the transmit holding register. A read returns the received character (unused upper bits 0) and clears the data-ready flag.
- R3: With `cs` high and `rsel` 1, a write loads the format register. A read returns status {3'b0, overrun, framing, parity, data-ready, tx-empty} in bits 7..0 and clears the three error bits. An error set in the same cycle as the read is kept.
- R4: Format register bits: [1:0] character length minus 5; [2] two stop bits when 1; [3] parity enable; [4] odd parity when 1, even when 0; [7:5] rate select. One bit lasts 16 × (BASE_DIV << rate) clocks. The reset value is 0x03 (8 bits, no parity, one stop, rate 0).
- R5: The `txd` line is 1 after reset and whenever nothing is being sent.
- R6: A transmitted frame is one 0 start bit, the character bits least significant first, an optional parity bit and one or two stop bits at 1, each one bit time long.
- R7: The parity bit makes the number of ones in the character plus parity even, or odd when odd parity is chosen. Only the character bits count.
- R8: A low pulse on `rxd` that ends before half a bit time is not taken as a start bit and delivers no character.
- R9: A received frame places its character in the receive register and sets data-ready. Bits above the configured length read as 0.
- R10: A received parity bit that disagrees with the configured parity sets the parity-error flag.
- R11: A first stop bit sampled as 0 sets the framing-error flag. The character is still delivered.
- R12: A character that arrives while data-ready is still set sets the overrun flag and replaces the older character.
- R13: The tx-empty flag is 1 after reset. A write to the holding register clears it, and it returns to 1 once the byte has moved into the shift register. A second byte written during a frame keeps it at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rsel | input | 1 | Register select: 0 data registers, 1 format/status |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
The hardest states to reach are the receiver's error and rejection paths, because the stimulus has to deform the incoming waveform at bit level. The bench serialises frames itself and can flip the parity bit or hold the first stop bit low for three quarters of a bit. It can also drive a start pulse shorter than half a bit, or send two frames without reading in between to cause an overrun. On the transmit side, the tx-empty flag falling to 0 and staying there is only seen by writing a second byte while the first frame is still on the line. The status is then read before that frame ends.

// File: rtl/sercom_pkg.sv
// Shared types and helpers for the serial port.
// Assumes the format byte layout listed in the brief (R4).
package sercom_pkg;

    typedef struct packed {
        logic [2:0] rate;
        logic       par_odd;
        logic       par_en;
        logic       two_stop;
        logic [1:0] len_code;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        SH_IDLE, SH_START, SH_DATA, SH_PAR, SH_STOP
    } shift_st_t;

    // Mask keeping only the configured character bits
    function automatic logic [7:0] char_mask(input logic [1:0] len_code);
        return 8'hFF >> (2'd3 - len_code);
    endfunction

    // Index of the last character bit (4..7)
    function automatic logic [2:0] last_idx(input logic [1:0] len_code);
        return {1'b0, len_code} + 3'd4;
    endfunction

    // Parity bit for a character under the chosen sense
    function automatic logic parity_of(input logic [7:0] d, input logic [1:0] len_code,
                                       input logic odd);
        return (^(d & char_mask(len_code))) ^ odd;
    endfunction

endpackage

// File: rtl/sercom_baud.sv
// Oversampling tick generator: one tick every BASE_DIV << rate clocks.
// Assumes BASE_DIV >= 1; a rate change takes effect at the next wrap.
module sercom_baud #(
    parameter int BASE_DIV = 2,
    localparam int DIV_W   = $clog2(BASE_DIV + 1) + 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rate,
    output logic       tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_m1;

    // Terminal count from the rate select
    always_comb div_m1 = (DIV_W'(BASE_DIV) << rate) - DIV_W'(1);

    // Free-running divider with registered tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div_m1) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end

    generate
        if (BASE_DIV > 1) begin : g_gap_chk
            assert_tick_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/sercom_tx.sv
// Transmitter: holding register plus frame shifter.
// Assumes tick is a one-cycle pulse at 16x the bit rate. The format is
// latched when a byte enters the shifter.
module sercom_tx
    import sercom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] len_code,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    input  logic       load_req,
    input  logic [7:0] wdata,
    output logic       txd,
    output logic       thre
);
    shift_st_t  st;
    logic [7:0] thr;
    logic [7:0] sh;
    logic [3:0] tcnt;
    logic [2:0] idx;
    logic [1:0] l_len;
    logic       l_par_en;
    logic       l_two;
    logic       par;
    logic       second;

    // Frame sequencer, holding register and line driver
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= SH_IDLE;
            txd      <= 1'b1;
            thr      <= '0;
            thre     <= 1'b1;
            sh       <= '0;
            tcnt     <= '0;
            idx      <= '0;
            l_len    <= 2'd3;
            l_par_en <= 1'b0;
            l_two    <= 1'b0;
            par      <= 1'b0;
            second   <= 1'b0;
        end else begin
            if (st == SH_IDLE) begin
                if (!thre) begin
                    st       <= SH_START;
                    txd      <= 1'b0;
                    sh       <= thr;
                    l_len    <= len_code;
                    l_par_en <= par_en;
                    l_two    <= two_stop;
                    par      <= parity_of(thr, len_code, par_odd);
                    tcnt     <= '0;
                    thre     <= 1'b1;
                end
            end else if (tick) begin
                if (tcnt != 4'd15) begin
                    tcnt <= tcnt + 4'd1;
                end else begin
                    tcnt <= '0;
                    case (st)
                        SH_START: begin
                            st  <= SH_DATA;
                            txd <= sh[0];
                            idx <= '0;
                        end
                        SH_DATA: begin
                            if (idx == last_idx(l_len)) begin
                                second <= 1'b0;
                                if (l_par_en) begin
                                    st  <= SH_PAR;
                                    txd <= par;
                                end else begin
                                    st  <= SH_STOP;
                                    txd <= 1'b1;
                                end
                            end else begin
                                idx <= idx + 3'd1;
                                sh  <= sh >> 1;
                                txd <= sh[1];
                            end
                        end
                        SH_PAR: begin
                            st     <= SH_STOP;
                            txd    <= 1'b1;
                            second <= 1'b0;
                        end
                        SH_STOP: begin
                            if (l_two && !second) second <= 1'b1;
                            else                  st     <= SH_IDLE;
                        end
                        default: st <= SH_IDLE;
                    endcase
                end
            end
            if (load_req) begin
                thr  <= wdata;
                thre <= 1'b0;
            end
        end
    end

    assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SH_IDLE) |-> txd);
    assert_fall_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> (st != SH_IDLE));
    assert_empty_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> !thre);

endmodule

// File: rtl/sercom_rx.sv
// Receiver: 16x oversampling, start check halfway through the bit, centre sampling.
// Assumes tick is a one-cycle pulse at 16x the bit rate and the format is
// held steady during a frame. The error flags stay set until status is read.
module sercom_rx
    import sercom_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] len_code,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rxd,
    input  logic       data_rd,
    input  logic       sts_rd,
    output logic [7:0] rbr,
    output logic       ready,
    output logic       pe,
    output logic       fe,
    output logic       ovr
);
    shift_st_t  st;
    logic [1:0] sync;
    logic       rx_s;
    logic [3:0] cnt;
    logic [2:0] idx;
    logic [7:0] sh;
    logic [7:0] aligned;
    logic       par_bit;
    logic       deliver;
    logic       pe_now;

    // Two-stage synchroniser on the serial input
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    always_comb rx_s = sync[1];

    // Delivery strobe, character alignment and parity verdict
    always_comb begin
        deliver = (st == SH_STOP) && tick && (cnt == 4'd15);
        aligned = sh >> (2'd3 - len_code);
        pe_now  = par_en && (par_bit != parity_of(aligned, len_code, par_odd));
    end

    // Frame sequencer and receive register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= SH_IDLE;
            cnt     <= '0;
            idx     <= '0;
            sh      <= '0;
            par_bit <= 1'b0;
            rbr     <= '0;
        end else if (tick) begin
            case (st)
                SH_IDLE: begin
                    if (!rx_s) begin
                        st  <= SH_START;
                        cnt <= '0;
                    end
                end
                SH_START: begin
                    if (cnt == 4'd7) begin
                        cnt <= '0;
                        idx <= '0;
                        sh  <= '0;
                        st  <= rx_s ? SH_IDLE : SH_DATA;
                    end else begin
                        cnt <= cnt + 4'd1;
                    end
                end
                SH_DATA: begin
                    if (cnt == 4'd15) begin
                        cnt <= '0;
                        sh  <= {rx_s, sh[7:1]};
                        if (idx == last_idx(len_code)) st <= par_en ? SH_PAR : SH_STOP;
                        else                           idx <= idx + 3'd1;
                    end else begin
                        cnt <= cnt + 4'd1;
                    end
                end
                SH_PAR: begin
                    if (cnt == 4'd15) begin
                        cnt     <= '0;
                        par_bit <= rx_s;
                        st      <= SH_STOP;
                    end else begin
                        cnt <= cnt + 4'd1;
                    end
                end
                SH_STOP: begin
                    if (cnt == 4'd15) begin
                        cnt <= '0;
                        rbr <= aligned;
                        st  <= SH_IDLE;
                    end else begin
                        cnt <= cnt + 4'd1;
                    end
                end
                default: st <= SH_IDLE;
            endcase
        end
    end

    // Status flags: set on delivery, cleared by the matching read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
            pe    <= 1'b0;
            fe    <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (deliver)      ready <= 1'b1;
            else if (data_rd) ready <= 1'b0;
            if (deliver && pe_now) pe <= 1'b1;
            else if (sts_rd)       pe <= 1'b0;
            if (deliver && !rx_s)  fe <= 1'b1;
            else if (sts_rd)       fe <= 1'b0;
            if (deliver && ready && !data_rd) ovr <= 1'b1;
            else if (sts_rd)                  ovr <= 1'b0;
        end
    end

    assert_ready_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> ready);
    assert_ready_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !deliver) |=> !ready);
    assert_err_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && !deliver) |=> !(pe || fe || ovr));
    assert_start_halfbit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SH_DATA) && $past(st) == SH_START |-> $past(!rx_s));

endmodule

// File: rtl/sercom_port.sv
// Serial port top: register decode, format register, tx/rx/baud instances.
// Assumes single-cycle strobes qualified by cs. Reads are combinational and
// their side effects land at the clock edge where the strobe is sampled.
module sercom_port
    import sercom_pkg::*;
#(
    parameter int BASE_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       rsel,
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       txd,
    input  logic       rxd
);
    logic [7:0] ctl;
    frame_cfg_t cfg;
    logic       wr_thr, wr_ctl, rd_rbr, rd_sts;
    logic       tick;
    logic       thre;
    logic [7:0] rbr;
    logic       ready, pe, fe, ovr;
    logic [7:0] sts;

    // Access decode from select, register bit and direction
    always_comb begin
        wr_thr = cs && wr_stb && !rsel;
        wr_ctl = cs && wr_stb &&  rsel;
        rd_rbr = cs && rd_stb && !rsel;
        rd_sts = cs && rd_stb &&  rsel;
        cfg    = frame_cfg_t'(ctl);
        sts    = {3'b000, ovr, fe, pe, ready, thre};
    end

    // Format register
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl <= 8'h03;
        else if (wr_ctl) ctl <= wdata;
    end

    // Read data multiplexer
    always_comb begin
        rdata = '0;
        if (rd_sts)      rdata = sts;
        else if (rd_rbr) rdata = rbr;
    end

    sercom_baud #(.BASE_DIV(BASE_DIV)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .rate (cfg.rate),
        .tick (tick)
    );

    sercom_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .len_code(cfg.len_code),
        .par_en  (cfg.par_en),
        .par_odd (cfg.par_odd),
        .two_stop(cfg.two_stop),
        .load_req(wr_thr),
        .wdata   (wdata),
        .txd     (txd),
        .thre    (thre)
    );

    sercom_rx u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .len_code(cfg.len_code),
        .par_en  (cfg.par_en),
        .par_odd (cfg.par_odd),
        .rxd     (rxd),
        .data_rd (rd_rbr),
        .sts_rd  (rd_sts),
        .rbr     (rbr),
        .ready   (ready),
        .pe      (pe),
        .fe      (fe),
        .ovr     (ovr)
    );

    assert_cs_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(ctl));
    assert_cs_rdata_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> (rdata == 8'h00));
    assert_fmt_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr_stb && rsel) |=> (ctl == $past(wdata)));

endmodule

// File: tb/sim_sercom_port.sv
// Scoreboard bench: the transmit driver queues expected frames and a line
// monitor decodes txd and compares. The receive driver serialises frames on rxd.
module sim_sercom_port;
    localparam int BASE_DIV = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rsel = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       txd;
    logic       rxd = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit mon_busy = 1'b0;
    logic [7:0] cur_ctl = 8'h03;
    logic [15:0] tx_q[$];

    always #2 clk = ~clk;

    sercom_port #(.BASE_DIV(BASE_DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rsel(rsel), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd)
    );

    function automatic int bit_clocks(input logic [7:0] c);
        return 16 * (BASE_DIV << c[7:5]);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rsel = sel; wr_stb = 1'b1; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr_stb = 1'b0;
    endtask

    task automatic bus_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rsel = sel; rd_stb = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd_stb = 1'b0;
    endtask

    task automatic set_fmt(input logic [7:0] c);
        bus_write(1'b1, c);
        cur_ctl = c;
    endtask

    // Driver: write a byte for sending and queue the expected frame
    task automatic send_tx(input logic [7:0] d);
        tx_q.push_back({cur_ctl, d});
        bus_write(1'b0, d);
    endtask

    task automatic tx_drain;
        wait (tx_q.size() == 0);
        @(negedge clk);
        while (mon_busy) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    // Serialise one frame onto rxd with optional parity or stop corruption
    task automatic rx_send(input logic [7:0] d, input bit flip_par, input bit bad_stop);
        int bc;
        int len;
        logic [7:0] m;
        bc  = bit_clocks(cur_ctl);
        len = 5 + int'(cur_ctl[1:0]);
        m   = d & (8'hFF >> (3 - cur_ctl[1:0]));
        @(negedge clk);
        rxd = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < len; i++) begin
            rxd = d[i];
            repeat (bc) @(negedge clk);
        end
        if (cur_ctl[3]) begin
            rxd = (^m) ^ cur_ctl[4] ^ flip_par;
            repeat (bc) @(negedge clk);
        end
        if (bad_stop) begin
            rxd = 1'b0;
            repeat (bc * 3 / 4) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (bc) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // Monitor: decode each frame on txd and compare with the queue head
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                if (tx_q.size() == 0) begin
                    check("R1", "unexpected frame on txd", 32'd1, 32'd0);
                    repeat (800) @(negedge clk);
                end else begin
                    logic [15:0] item;
                    logic [7:0] c, d, got, exp_d;
                    logic st, p, s1, s2, exp_p;
                    int bc;
                    int len;
                    mon_busy = 1'b1;
                    item = tx_q.pop_front();
                    c = item[15:8]; d = item[7:0];
                    bc = bit_clocks(c);
                    len = 5 + int'(c[1:0]);
                    repeat (bc / 2 - 1) @(negedge clk);
                    st = txd;
                    got = '0;
                    for (int i = 0; i < len; i++) begin
                        repeat (bc) @(negedge clk);
                        got[i] = txd;
                    end
                    p = 1'b0;
                    if (c[3]) begin
                        repeat (bc) @(negedge clk);
                        p = txd;
                    end
                    repeat (bc) @(negedge clk);
                    s1 = txd;
                    s2 = 1'b1;
                    if (c[2]) begin
                        repeat (bc) @(negedge clk);
                        s2 = txd;
                    end
                    exp_d = d & (8'hFF >> (3 - c[1:0]));
                    exp_p = c[3] ? ((^exp_d) ^ c[4]) : 1'b0;
                    check("R6 R7 R4", "tx frame {start,data,par,stop1,stop2}",
                          {20'd0, st, got, p, s1, s2},
                          {20'd0, 1'b0, exp_d, exp_p, 1'b1, 1'b1});
                    mon_busy = 1'b0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Stimulus
    initial begin
        logic [7:0] r;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R5", "txd after reset", {31'd0, txd}, 32'd1);
        check("R1", "rdata with cs low", {24'd0, rdata}, 32'd0);
        bus_read(1'b1, r);
        check("R3 R13", "status after reset", {24'd0, r}, 32'h01);

        // 8N1, two back-to-back bytes; empty flag held low by second byte
        send_tx(8'hA5);
        send_tx(8'h3C);
        bus_read(1'b1, r);
        check("R13", "tx-empty with byte pending", {31'd0, r[0]}, 32'd0);
        tx_drain();
        bus_read(1'b1, r);
        check("R13", "tx-empty after drain", {31'd0, r[0]}, 32'd1);
        check("R5", "txd idle after frames", {31'd0, txd}, 32'd1);

        // 7 bits even parity: top bit masked
        set_fmt(8'h0A);
        send_tx(8'hD5);
        tx_drain();

        // 5 bits odd parity two stops
        set_fmt(8'h1C);
        send_tx(8'h13);
        tx_drain();

        // Strobes with cs low must do nothing
        @(negedge clk);
        rsel = 1'b1; wr_stb = 1'b1; wdata = 8'h03;
        @(negedge clk);
        rsel = 1'b0; wdata = 8'hFF;
        @(negedge clk);
        wr_stb = 1'b0; rd_stb = 1'b1; rsel = 1'b1;
        #1 check("R1", "rdata on read with cs low", {24'd0, rdata}, 32'd0);
        @(negedge clk);
        rd_stb = 1'b0;
        repeat (200) @(negedge clk);
        send_tx(8'h0A);
        tx_drain();

        // Slower rate select
        set_fmt(8'h23);
        send_tx(8'h81);
        tx_drain();

        // Receive 8N1
        set_fmt(8'h03);
        rx_send(8'h5A, 1'b0, 1'b0);
        bus_read(1'b1, r);
        check("R9", "status after rx", {24'd0, r}, 32'h03);
        bus_read(1'b0, r);
        check("R2 R9", "rx data", {24'd0, r}, 32'h5A);
        bus_read(1'b1, r);
        check("R2", "ready cleared by data read", {24'd0, r}, 32'h01);

        // Short low glitch rejected
        @(negedge clk);
        rxd = 1'b0;
        repeat (bit_clocks(cur_ctl) / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * bit_clocks(cur_ctl)) @(negedge clk);
        bus_read(1'b1, r);
        check("R8", "status after glitch", {24'd0, r}, 32'h01);

        // 5-bit character, upper bits read as 0
        set_fmt(8'h00);
        rx_send(8'hF5, 1'b0, 1'b0);
        bus_read(1'b0, r);
        check("R9", "5-bit rx data", {24'd0, r}, 32'h15);

        // Even parity: good then bad
        set_fmt(8'h0B);
        rx_send(8'h33, 1'b0, 1'b0);
        bus_read(1'b1, r);
        check("R10", "status with good parity", {24'd0, r}, 32'h03);
        bus_read(1'b0, r);
        rx_send(8'h33, 1'b1, 1'b0);
        bus_read(1'b1, r);
        check("R10", "status with bad parity", {24'd0, r}, 32'h07);
        bus_read(1'b1, r);
        check("R3", "parity error cleared by status read", {24'd0, r}, 32'h03);
        bus_read(1'b0, r);
        check("R10", "data kept with bad parity", {24'd0, r}, 32'h33);

        // Framing error
        set_fmt(8'h03);
        rx_send(8'h44, 1'b0, 1'b1);
        bus_read(1'b1, r);
        check("R11", "status with low stop", {24'd0, r}, 32'h0B);
        bus_read(1'b0, r);
        check("R11", "data with low stop", {24'd0, r}, 32'h44);
        bus_read(1'b1, r);
        check("R3", "framing error cleared", {24'd0, r}, 32'h01);

        // Overrun
        rx_send(8'h11, 1'b0, 1'b0);
        rx_send(8'h22, 1'b0, 1'b0);
        bus_read(1'b1, r);
        check("R12", "status after overrun", {24'd0, r}, 32'h13);
        bus_read(1'b0, r);
        check("R12", "newest data kept", {24'd0, r}, 32'h22);
        bus_read(1'b1, r);
        check("R12", "status after clearing", {24'd0, r}, 32'h01);

        repeat (20) @(negedge clk);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule